// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a physical address through a four-entry segment table held in flip-flops. The two top address bits pick a segment and the remaining twelve bits are an offset into it. Each table entry carries a physical base, a length limit, a present flag and a write-permission flag. On every request the unit adds the offset to the chosen base, compares the offset against the limit and checks a store against the write permission. It returns either a physical address or a fault with a two-bit cause, one cycle after the request.

The table is loaded through a configuration port that only takes effect while the privilege input is high. A configuration write made without privilege leaves the table as it was and raises a one-cycle reject flag. A faulting request never presents a physical address, so a downstream memory port can use `rsp_valid && !rsp_fault` as its access enable.

Top module: `segx_unit`

## Requirements
- R1: After reset every segment entry is marked absent, and `rsp_valid` and `cfg_reject` are low; a request before any table write faults with cause 2'b01.
- R2: Address bits [13:12] select the segment and bits [11:0] form the offset; a request that passes all checks returns cause 2'b00, `rsp_fault` low and `rsp_paddr` equal to the segment base plus the zero-extended offset.
- R3: An offset greater than or equal to the selected segment's limit returns cause 2'b10 (limit violation); an offset of limit minus one is accepted, and a limit of zero rejects every offset.
- R4: A request that selects an entry whose present flag is clear returns cause 2'b01 (absent segment).
- R5: `req_kind` encodes 2'b00 instruction fetch, 2'b01 load, 2'b10 and 2'b11 store; fetches and loads are allowed in every present segment, while a store to an entry whose write-permission flag is clear returns cause 2'b11 (protection violation).
- R6: When several checks fail, the cause reported is absent segment first, then limit, then protection; on any fault `rsp_fault` is high and `rsp_paddr` is zero.
- R7: A configuration write with `cfg_we` and `cfg_priv` both high replaces entry `cfg_idx` at the clock edge; a request in the same cycle is translated with the old entry and requests from the next cycle use the new one.
- R8: A configuration write with `cfg_priv` low leaves the table unchanged and drives `cfg_reject` high in the following cycle only.
- R9: `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise; when `rsp_valid` is low, `rsp_paddr`, `rsp_fault` and `rsp_cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present this cycle |
| req_vaddr | input | 14 | Virtual address: segment in [13:12], offset in [11:0] |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 1x store |
| cfg_we | input | 1 | Table write request |
| cfg_priv | input | 1 | Privileged mode; table writes only take effect when high |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | Physical base for the entry |
| cfg_limit | input | 13 | Segment length; offsets at or above it fault |
| cfg_seg_valid | input | 1 | Present flag for the entry |
| cfg_seg_writable | input | 1 | Write permission for the entry |
| rsp_valid | output | 1 | Registered result present |
| rsp_paddr | output | 16 | Physical address, zero on fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 2 | 00 none, 01 absent, 10 limit, 11 protection |
| cfg_reject | output | 1 | Previous cycle's table write was refused for lack of privilege |

## Verification
Every result of this block lands exactly one clock edge after its stimulus: a request's address or fault, the reject flag for an unprivileged write, and the visibility of a privileged table write to the next request. The bench drives inputs on the falling edge, computes the expected response from its own table model using the table as it stood before that edge, then updates the model and compares all outputs on the next falling edge, so every comparison sits one edge after its cause. Idle cycles are compared as well, which covers the zeroed outputs when no response is due.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int VA_W     = 14;
    localparam int SEG_BITS = 2;
    localparam int NUM_SEGS = 1 << SEG_BITS;
    localparam int OFF_W    = VA_W - SEG_BITS;
    localparam int LIM_W    = OFF_W + 1;
    localparam int PA_W     = 16;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_LIMIT = 2'b10,
        CAUSE_PROT  = 2'b11
    } fault_cause_e;

    typedef enum logic [1:0] {
        ACC_FETCH     = 2'b00,
        ACC_LOAD      = 2'b01,
        ACC_STORE     = 2'b10,
        ACC_STORE_ALT = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic             present;
        logic             writable;
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
    } seg_entry_t;

    typedef seg_entry_t [NUM_SEGS-1:0] seg_table_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            fault;
        fault_cause_e    cause;
    } xlate_rsp_t;

endpackage

// File: rtl/segx_table.sv
module segx_table
    import segx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_priv,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  seg_entry_t          wr_entry,
    output seg_table_t          table_o,
    output logic                reject_o
);

    typedef struct packed {
        seg_table_t ents;
        logic       reject;
    } tbl_state_t;

    tbl_state_t state_d, state_q;
    logic [NUM_SEGS-1:0] wr_hit;

    // One decoder slice per entry.
    generate
        for (genvar g = 0; g < NUM_SEGS; g++) begin : g_hit
            assign wr_hit[g] = wr_en && wr_priv && (wr_idx == SEG_BITS'(g));
        end
    endgenerate

    always_comb begin
        state_d        = state_q;
        state_d.reject = wr_en && !wr_priv;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (wr_hit[i]) begin
                state_d.ents[i] = wr_entry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign table_o  = state_q.ents;
    assign reject_o = state_q.reject;

endmodule

// File: rtl/segx_lookup.sv
module segx_lookup
    import segx_pkg::*;
(
    input  seg_table_t       table_i,
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [1:0]       kind_i,
    output logic [PA_W-1:0]  paddr_o,
    output fault_cause_e     cause_o
);

    logic [SEG_BITS-1:0] seg_sel;
    logic [OFF_W-1:0]    offset;
    seg_entry_t          ent;
    logic [PA_W-1:0]     sum;
    logic                over_limit;
    logic                is_store;
    acc_kind_e           kind;

    always_comb begin
        seg_sel    = vaddr_i[VA_W-1:OFF_W];
        offset     = vaddr_i[OFF_W-1:0];
        ent        = table_i[seg_sel];
        kind       = acc_kind_e'(kind_i);
        is_store   = (kind == ACC_STORE) || (kind == ACC_STORE_ALT);
        sum        = ent.base + PA_W'(offset);
        over_limit = ({1'b0, offset} >= ent.limit);

        // Absent beats limit, limit beats protection.
        if (!ent.present) begin
            cause_o = CAUSE_ABSENT;
        end else if (over_limit) begin
            cause_o = CAUSE_LIMIT;
        end else if (is_store && !ent.writable) begin
            cause_o = CAUSE_PROT;
        end else begin
            cause_o = CAUSE_NONE;
        end

        paddr_o = (cause_o == CAUSE_NONE) ? sum : '0;
    end

endmodule

// File: rtl/segx_unit.sv
module segx_unit
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [13:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [1:0]       cfg_idx,
    input  logic [15:0]      cfg_base,
    input  logic [12:0]      cfg_limit,
    input  logic             cfg_seg_valid,
    input  logic             cfg_seg_writable,
    output logic             rsp_valid,
    output logic [15:0]      rsp_paddr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
    ,output logic            cfg_reject
);

    seg_entry_t   wr_entry;
    seg_table_t   tbl;
    logic [PA_W-1:0] lk_paddr;
    fault_cause_e lk_cause;
    xlate_rsp_t   rsp_d, rsp_q;

    always_comb begin
        wr_entry.present  = cfg_seg_valid;
        wr_entry.writable = cfg_seg_writable;
        wr_entry.base     = cfg_base;
        wr_entry.limit    = cfg_limit;
    end

    segx_table i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_priv  (cfg_priv),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .table_o  (tbl),
        .reject_o (cfg_reject)
    );

    segx_lookup i_lookup (
        .table_i (tbl),
        .vaddr_i (req_vaddr),
        .kind_i  (req_kind),
        .paddr_o (lk_paddr),
        .cause_o (lk_cause)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.paddr = lk_paddr;
            rsp_d.cause = lk_cause;
            rsp_d.fault = (lk_cause != CAUSE_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;

endmodule

// File: rtl/segx_checker.sv
module segx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        cfg_we,
    input logic        cfg_priv,
    input logic        rsp_valid,
    input logic [15:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic        cfg_reject
);

    a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0) && !rsp_fault && (rsp_cause == 2'b00));

    a_r6_fault_hides_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r6_fault_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)));

    a_r8_user_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> cfg_reject);

    a_r8_reject_only_on_user_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_priv) |=> !cfg_reject);

endmodule

bind segx_unit segx_checker i_segx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cfg_we     (cfg_we),
    .cfg_priv   (cfg_priv),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_cause  (rsp_cause),
    .cfg_reject (cfg_reject)
);

// File: tb/test_segx_unit.sv
module test_segx_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_limit = '0;
    logic        cfg_seg_valid = 1'b0;
    logic        cfg_seg_writable = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        cfg_reject;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Behavioural table model.
    int m_base [4];
    int m_lim  [4];
    bit m_pres [4];
    bit m_wr   [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    segx_unit i_segx_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_seg_valid(cfg_seg_valid), .cfg_seg_writable(cfg_seg_writable),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .cfg_reject(cfg_reject)
    );

    task automatic compare(input string tag, input bit ev, input int ep,
                           input bit ef, input int ec, input bit er);
        vectors++;
        if (rsp_valid !== ev || rsp_paddr !== 16'(ep) || rsp_fault !== ef ||
            rsp_cause !== 2'(ec) || cfg_reject !== er) begin
            fails++;
            $display("FAIL %s: got v=%0b pa=%h f=%0b c=%0d rej=%0b, want v=%0b pa=%h f=%0b c=%0d rej=%0b",
                     tag, rsp_valid, rsp_paddr, rsp_fault, rsp_cause, cfg_reject,
                     ev, 16'(ep), ef, ec, er);
        end
    endtask

    // Drive one cycle at a falling edge, predict, then compare at the next falling edge.
    task automatic cycle(input string tag, input bit rv, input int va, input int kind,
                         input bit we, input bit priv, input int idx, input int base,
                         input int lim, input bit pres, input bit wrt);
        int seg, off, ep, ec;
        bit ef;
        req_valid = rv; req_vaddr = 14'(va); req_kind = 2'(kind);
        cfg_we = we; cfg_priv = priv; cfg_idx = 2'(idx); cfg_base = 16'(base);
        cfg_limit = 13'(lim); cfg_seg_valid = pres; cfg_seg_writable = wrt;
        seg = (va >> 12) & 3;
        off = va & 'hfff;
        ep = 0; ec = 0; ef = 0;
        if (rv) begin
            if (!m_pres[seg])                     ec = 1;
            else if (off >= m_lim[seg])           ec = 2;
            else if (kind >= 2 && !m_wr[seg])     ec = 3;
            else                                  ep = (m_base[seg] + off) & 'hffff;
            ef = (ec != 0);
        end
        if (we && priv) begin
            m_base[idx] = base; m_lim[idx] = lim; m_pres[idx] = pres; m_wr[idx] = wrt;
        end
        @(negedge clk);
        compare(tag, rv, ep, ef, ec, we && !priv);
    endtask

    task automatic req(input string tag, input int va, input int kind);
        cycle(tag, 1, va, kind, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(input string tag);
        cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic cfg(input string tag, input bit priv, input int idx, input int base,
                       input int lim, input bit pres, input bit wrt);
        cycle(tag, 0, 0, 0, 1, priv, idx, base, lim, pres, wrt);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: run did not complete, got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_pres[i] = 0; m_wr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare("R1 reset", 0, 0, 0, 0, 0);
        req("R1 table empty after reset", 'h0240, 1);

        // R7: privileged table load
        cfg("R7 load seg0", 1, 0, 'h4000, 'h700, 1, 0);
        cfg("R7 load seg1", 1, 1, 'h0000, 'h500, 1, 1);
        cfg("R7 load seg2 absent", 1, 2, 'h0000, 'h000, 0, 0);
        cfg("R7 load seg3", 1, 3, 'h2000, 'h1000, 1, 1);

        // R8: user writes are ignored and flagged
        cfg("R8 user write seg2", 0, 2, 'h3000, 'h100, 1, 1);
        req("R8 seg2 still absent", 'h2010, 1);
        cfg("R8 user write seg0", 0, 0, 'h9000, 'hfff, 1, 1);
        req("R8 seg0 base unchanged", 'h0240, 1);
        idle("R8 reject lasts one cycle");

        // R2: valid translations
        req("R2 0x0240", 'h0240, 1);
        req("R2 0x1108", 'h1108, 1);
        req("R2 0x3002 fetch", 'h3002, 0);
        req("R2 seg0 offset 0", 'h0000, 0);

        // R3: limit edges
        req("R3 limit-1 ok", 'h06ff, 1);
        req("R3 offset==limit", 'h0700, 1);
        req("R3 0x1600", 'h1600, 1);
        req("R3 seg3 top offset", 'h3fff, 1);
        req("R3 seg1 limit-1", 'h14ff, 2);

        // R4: absent segment
        req("R4 0x265c", 'h265c, 1);
        req("R4 seg2 fetch", 'h2000, 0);

        // R5: protection
        req("R5 store read-only", 'h0240, 2);
        req("R5 store alt read-only", 'h0100, 3);
        req("R5 store writable", 'h1108, 2);
        req("R5 store alt writable", 'h3400, 3);
        req("R5 fetch read-only", 'h0100, 0);

        // R6: priorities
        req("R6 absent over store", 'h2700, 2);
        req("R6 limit over prot", 'h0800, 2);
        req("R6 limit over prot alt", 'h0fff, 3);

        // R9: idle gaps
        idle("R9 idle 1");
        req("R9 after idle", 'h1004, 1);
        idle("R9 idle 2");

        // R7: same-cycle write and request
        cycle("R7 same cycle old entry", 1, 'h1010, 1, 1, 1, 1, 'h8000, 'h500, 1, 1);
        req("R7 new entry next cycle", 'h1010, 1);

        // R3: zero limit rejects all offsets
        cfg("R3 seg3 limit zero", 1, 3, 'h2000, 0, 1, 1);
        req("R3 zero limit offset 0", 'h3000, 1);
        cfg("R7 restore seg3", 1, 3, 'h2000, 'h1000, 1, 1);

        // R2: sweep of offsets and kinds across all segments
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                req("R2 sweep", (s << 12) | ((k * 'h2a7 + s * 'h133) & 'hfff), k);
            end
        end
        idle("R9 final idle");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule